// File: doc/BRIEF.md
# Cycle Counter with Overflow Interrupt

This block is the clock-cycle counter of a performance-monitoring unit. It advances a 63-bit count by one on every clock while its inhibit input is low, and freezes the count while that input is high. The 64-bit value it presents to software holds the count in bits 62:0 and a sticky overflow flag in bit 63.

When the count rolls over from all ones to zero, the block records the event in two places. It sets the overflow flag in bit 63 and it sets its own bit, bit 0, of a status word that it shares with the event counters. If the status bit was clear before the rollover, the block also emits a single-cycle interrupt request. A software write loads the count from bits 62:0 of the write data and the flag from bit 63. Writing the flag as zero also clears the status bit, which re-arms the interrupt.

Top module: `cyc_counter_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ctr_value` is 0, `ovf_sts0` is 0 and `pm_irq` is 0. Counting is enabled once reset falls.
- R2: On each clock edge with `cy_inhibit` low and `wr_en` low, bits 62:0 of `ctr_value` increase by one.
- R3: On each clock edge with `cy_inhibit` high and `wr_en` low, `ctr_value` keeps its value. When `cy_inhibit` returns low, counting continues from the held value.
- R4: A clock edge with `wr_en` high loads bits 62:0 of `ctr_value` from `wr_data[62:0]` and bit 63 from `wr_data[63]`. Bit 63 never enters the count.
- R5: A write with `wr_data[63]` = 0 clears `ovf_sts0`. A write with `wr_data[63]` = 1 leaves `ovf_sts0` unchanged.
- R6: When the count is all ones and advances while `ovf_sts0` is 0, the count becomes 0 and `ctr_value[63]` becomes 1. In the same cycle `ovf_sts0` becomes 1 and `pm_irq` is 1.
- R7: `pm_irq` is high for exactly one cycle for each qualifying rollover.
- R8: When the count advances from all ones while `ovf_sts0` is already 1, the count becomes 0, `ctr_value[63]` and `ovf_sts0` keep their values, and `pm_irq` stays low.
- R9: A write takes precedence over counting, over a rollover and over inhibit in the same cycle. A write on a would-be rollover edge raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| cy_inhibit | input | 1 | Holds the count while high |
| wr_en | input | 1 | Software write strobe for the counter register |
| wr_data | input | 64 | Write data: bit 63 is the flag, bits 62:0 are the count |
| ctr_value | output | 64 | Readable counter register: {flag, count} |
| ovf_sts0 | output | 1 | Bit 0 of the shared overflow-status word |
| pm_irq | output | 1 | One-cycle performance-monitor interrupt request |

## Verification
The checker examines every cycle for the following: the increment, the hold under inhibit, the load on write, the clearing of the status bit by a zero flag write, the coupling between the rising status bit and the interrupt, the one-cycle pulse width, and the absence of a second interrupt while the status bit is set. Some behaviours show up only in the bench's directed scenarios. These include the exact rollover to zero from a count preloaded near all ones, the flag's persistence across a rollover with the status bit set, a write that lands on a would-be rollover edge, and resumption after inhibit.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_WRAP = 2'd2,
        CNT_LOAD = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic of;
        logic sts;
        logic irq;
    } ovf_t;

    function automatic cnt_act_e pick_act(input logic run, input logic ld,
                                          input logic at_max);
        if (ld)
            return CNT_LOAD;
        else if (!run)
            return CNT_HOLD;
        else if (at_max)
            return CNT_WRAP;
        else
            return CNT_INC;
    endfunction

    function automatic ovf_t next_flags(input ovf_t cur, input logic ld,
                                        input logic ld_of, input logic wrap);
        ovf_t nxt;
        nxt     = cur;
        nxt.irq = 1'b0;
        if (ld) begin
            nxt.of = ld_of;
            if (!ld_of)
                nxt.sts = 1'b0;
        end else if (wrap && !cur.sts) begin
            nxt.of  = 1'b1;
            nxt.sts = 1'b1;
            nxt.irq = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    import cyc_pkg::*;

    cnt_act_e act;

    always_comb act = pick_act(run, ld, &count);

    assign wrap = (act == CNT_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (act)
                CNT_LOAD: count <= ld_val;
                CNT_INC:  count <= count + CNT_W'(1);
                CNT_WRAP: count <= '0;
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cyc_ovf_flags.sv
module cyc_ovf_flags (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic           ld_of,
    input  logic           wrap,
    output cyc_pkg::ovf_t  flags
);
    import cyc_pkg::*;

    ovf_t nxt;

    always_comb nxt = next_flags(flags, ld, ld_of, wrap);

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= nxt;
    end

endmodule

// File: rtl/cyc_counter_top.sv
module cyc_counter_top #(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cy_inhibit,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctr_value,
    output logic             ovf_sts0,
    output logic             pm_irq
);
    import cyc_pkg::*;

    logic [CNT_W-1:0] count;
    logic             wrap;
    ovf_t             flags;

    cyc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .run    (!cy_inhibit),
        .ld     (wr_en),
        .ld_val (wr_data[CNT_W-1:0]),
        .count  (count),
        .wrap   (wrap)
    );

    cyc_ovf_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .ld    (wr_en),
        .ld_of (wr_data[REG_W-1]),
        .wrap  (wrap),
        .flags (flags)
    );

    assign ctr_value = {flags.of, count};
    assign ovf_sts0  = flags.sts;
    assign pm_irq    = flags.irq;

endmodule

// File: rtl/cyc_counter_chk.sv
module cyc_counter_chk #(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cy_inhibit,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] ctr_value,
    input logic             ovf_sts0,
    input logic             pm_irq
);

    // R2
    count_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!cy_inhibit && !wr_en && (ctr_value[CNT_W-1:0] != '1))
        |=> (ctr_value[CNT_W-1:0] == $past(ctr_value[CNT_W-1:0]) + CNT_W'(1)));

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cy_inhibit && !wr_en) |=> $stable(ctr_value));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctr_value == $past(wr_data)));

    // R5
    sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[REG_W-1]) |=> !ovf_sts0);

    // R6
    irq_on_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_sts0) |-> (pm_irq && ctr_value[REG_W-1]));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pm_irq |=> !pm_irq);

    // R8
    no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_sts0 && !wr_en) |=> (!pm_irq && ovf_sts0));

    // R9
    wr_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !pm_irq);

endmodule

bind cyc_counter_top cyc_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cyc_counter_top.sv
module sim_cyc_counter_top;

    localparam int CW = 63;
    localparam logic [CW-1:0] MAXC = '1;

    typedef struct {
        int          due;
        string       req;
        logic [CW:0] val;
        logic        sts;
        logic        irq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cy_inhibit = 1'b0;
    logic        wr_en = 1'b0;
    logic [CW:0] wr_data = '0;
    logic [CW:0] ctr_value;
    logic        ovf_sts0;
    logic        pm_irq;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    exp_t sb[$];

    logic [CW-1:0] m_cnt = '0;
    logic          m_of  = 1'b0;
    logic          m_sts = 1'b0;

    cyc_counter_top #(.CNT_W(CW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .cy_inhibit (cy_inhibit),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctr_value  (ctr_value),
        .ovf_sts0   (ovf_sts0),
        .pm_irq     (pm_irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input string req, input logic irq_e);
        exp_t e;
        e.due = cyc + 1;
        e.req = req;
        e.val = {m_of, m_cnt};
        e.sts = m_sts;
        e.irq = irq_e;
        sb.push_back(e);
    endtask

    task automatic tick(input logic inh, input string req);
        logic irq_e;
        @(negedge clk);
        rst = 1'b0;
        wr_en = 1'b0;
        cy_inhibit = inh;
        irq_e = 1'b0;
        if (!inh) begin
            if (m_cnt == MAXC) begin
                m_cnt = '0;
                if (!m_sts) begin
                    m_sts = 1'b1;
                    m_of  = 1'b1;
                    irq_e = 1'b1;
                end
            end else begin
                m_cnt = m_cnt + CW'(1);
            end
        end
        push(req, irq_e);
    endtask

    task automatic wr(input logic [CW:0] data, input logic inh, input string req);
        @(negedge clk);
        rst = 1'b0;
        cy_inhibit = inh;
        wr_en = 1'b1;
        wr_data = data;
        m_cnt = data[CW-1:0];
        m_of  = data[CW];
        if (!data[CW])
            m_sts = 1'b0;
        push(req, 1'b0);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (e.due != cyc || ctr_value !== e.val || ovf_sts0 !== e.sts
                || pm_irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s cyc=%0d: value=%h sts=%b irq=%b expected value=%h sts=%b irq=%b",
                         e.req, cyc, ctr_value, ovf_sts0, pm_irq, e.val, e.sts, e.irq);
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired: sb=%0d expected 0", sb.size());
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        @(negedge clk);
        push("R1", 1'b0);                 // reset state
        tick(1'b0, "R1");                 // first cycle after reset: counts to 1
        // R2: free running
        repeat (4) tick(1'b0, "R2");
        // R3: hold under inhibit then resume
        repeat (3) tick(1'b1, "R3");
        repeat (2) tick(1'b0, "R3");
        // R4: load, bit 63 goes to flag only
        wr(64'h0000_0000_0012_3456, 1'b0, "R4");
        tick(1'b0, "R4");
        wr(64'h8000_0000_0000_0005, 1'b0, "R4");
        tick(1'b0, "R4");
        wr(64'h0000_0000_0000_0005, 1'b0, "R4");
        // R6: rollover with status clear
        wr({1'b0, MAXC - CW'(2)}, 1'b0, "R4");
        tick(1'b0, "R2");
        tick(1'b0, "R2");
        tick(1'b0, "R6");
        // R7: pulse drops next cycle
        tick(1'b0, "R7");
        tick(1'b0, "R7");
        // R5: write with flag 1 keeps status
        wr({1'b1, MAXC - CW'(1)}, 1'b0, "R5");
        tick(1'b0, "R2");
        // R8: rollover while status set
        tick(1'b0, "R8");
        tick(1'b0, "R8");
        // R5: write with flag 0 clears status
        wr(64'h0000_0000_0000_000A, 1'b0, "R5");
        tick(1'b0, "R5");
        // R9: write while inhibited, then hold
        wr(64'h0000_0000_0000_0100, 1'b1, "R9");
        tick(1'b1, "R9");
        // R9: write on would-be rollover edge
        wr({1'b0, MAXC}, 1'b0, "R4");
        wr(64'h0000_0000_0000_0007, 1'b0, "R9");
        tick(1'b0, "R9");
        // R3: inhibited at all ones: no rollover, no interrupt
        wr({1'b0, MAXC}, 1'b0, "R4");
        repeat (2) tick(1'b1, "R3");
        tick(1'b0, "R6");
        tick(1'b0, "R7");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R7 leftover expectations: %0d expected 0", sb.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule